// File: doc/BRIEF.md
# Secondary Processor Wake-up Sequencer

This block runs the multiprocessor wake-up handshake in hardware, so that no boot software has to do it. A one-cycle `start` pulse launches a fixed sequence. The block first clears an external "reported-in" processor counter. It then writes three broadcast commands, all addressed to every processor except the issuer, into an interprocessor command register: first a reset-class (INIT) message, then two start-up messages that carry a configurable entry vector.

After each write, the block reads the command register's delivery-status bit once per cycle until that bit shows idle. It then waits a timed gap: a long one after the INIT message and a short one after each start-up message. Each gap is measured in ticks of a reference timer. That tick is divided down from the block clock.

Once the third gap has expired, the block samples the processor count and compares it with the expected number. It reports the outcome on a done/pass/count/error handshake. If a delivery-status poll never goes idle, the block abandons the sequence and reports an error code that names the step that stalled.

Top module: `cpu_wake_seq`

## Requirements
- R1: When an accepted `start` pulse arrives, `cnt_clr` is high for exactly the following cycle, and this happens before any command write is made.
- R2: Exactly three command writes are made, in this order. First comes INIT = 32'h000C4500. Then two start-up writes follow, each 32'h000C4600 with `start_vec` in bits 7:0. The fields are: bits 19:18 = 2'b11 (all except self), bit 14 = 1 (assert), and bits 10:8 = delivery mode (3'b101 INIT, 3'b110 start-up).
- R3: From the cycle after each write, `cmd_rd` is high in every cycle, and bit 12 of `cmd_rdata` is sampled. The sequence advances only after a sample in which bit 12 reads 0 (idle).
- R4: The reference tick comes every CLK_HZ/REF_HZ clocks and runs freely from reset. After INIT goes idle, a reload of REF_HZ/(1000000/LONG_US) ticks must elapse before the next write.
- R5: After each start-up write goes idle, a reload of REF_HZ/(1000000/SHORT_US) ticks must elapse. After the second of these delays, `cpu_count` is sampled.
- R6: At the end of a sequence that completes, `done` is a one-cycle pulse. At that point `final_count` equals the sampled count, `pass` is 1 exactly when that count equals `exp_count`, and `err_code` = 0. These outputs hold until the next start.
- R7: If POLL_MAX consecutive status samples read busy, the sequence aborts. `done` pulses with `pass` = 0 and `final_count` = 0, and `err_code` names the stalled step: 1 INIT, 2 first start-up, 3 second start-up. No further write follows.
- R8: A `start` pulse that arrives while a sequence is running is ignored.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches a sequence |
| start_vec | input | 8 | Entry vector carried by the start-up messages |
| exp_count | input | CW | Expected number of processors that report in |
| cpu_count | input | CW | Current value of the reported-in counter |
| cnt_clr | output | 1 | Clears the reported-in counter |
| cmd_wr | output | 1 | Write strobe for the command register |
| cmd_wdata | output | 32 | Command word to be written |
| cmd_rd | output | 1 | Read strobe for status polling |
| cmd_rdata | input | 32 | Command register read-back (bit 12 = pending) |
| done | output | 1 | End-of-sequence pulse |
| pass | output | 1 | Final count matched expected |
| final_count | output | CW | Sampled processor count |
| err_code | output | 2 | 0 none, 1..3 step whose poll timed out |

## Verification
The bench drives the pending bit with a different busy length at each step. This catches a design that starts its delay on the write itself instead of on the idle read, because such a design would write its next command too early. The bench makes the poll stall at each of the three steps in turn. A design with a wrong step encoding would report the wrong error code, and a design with a missing abort would keep on writing.

Mismatched counts and a start pulse sent in the middle of a sequence expose two more faults: a pass flag tied to completion rather than to the count, and a sequence that restarts partway through. Writes are time-stamped so that the long and short gaps can be checked against their computed reloads. A design that swapped the two reloads, or that ignored the reference divisor, would break those gap bounds.

// File: rtl/cpu_wake_pkg.sv
// Package: shared types and command-word construction for the wake-up sequencer.
// Assumes the command register field layout: shorthand 19:18, level 14,
// delivery status 12, delivery mode 10:8, vector 7:0.
package cpu_wake_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLEAR,
        S_WRITE,
        S_POLL,
        S_WAIT,
        S_CHECK
    } seq_state_t;

    localparam logic [2:0] MODE_INIT  = 3'b101;
    localparam logic [2:0] MODE_START = 3'b110;
    localparam int         PEND_BIT   = 12;

    // Build a broadcast-to-others, level-assert command word.
    function automatic logic [31:0] build_cmd(input logic [2:0] mode, input logic [7:0] vec);
        logic [31:0] w;
        w        = 32'h0;
        w[19:18] = 2'b11;
        w[14]    = 1'b1;
        w[10:8]  = mode;
        w[7:0]   = vec;
        return w;
    endfunction

endpackage

// File: rtl/wake_ref_div.sv
// Module: divides the block clock down to the reference timer tick.
// Assumes DIV >= 1; the tick is free-running from reset and is one cycle wide.
module wake_ref_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_cnt
            localparam int DW = $clog2(DIV);
            logic [DW-1:0] cnt_q;

            // Count clocks modulo DIV.
            always_ff @(posedge clk) begin
                if (!rst_n)                      cnt_q <= '0;
                else if (cnt_q == DW'(DIV - 1))  cnt_q <= '0;
                else                             cnt_q <= cnt_q + 1'b1;
            end

            assign tick = rst_n && (cnt_q == DW'(DIV - 1));

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R4
        end
    endgenerate
endmodule

// File: rtl/wake_delay_timer.sv
// Module: down-counter for the post-command delays, measured in reference ticks.
// Assumes load and a tick never need to be honoured in the same cycle (load wins).
module wake_delay_timer #(
    parameter int TW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          tick,
    output logic          zero
);
    logic [TW-1:0] rem_q;

    // Load a reload value, or step down once per reference tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rem_q <= '0;
        else if (load)                  rem_q <= load_val;
        else if (tick && rem_q != '0)   rem_q <= rem_q - 1'b1;
    end

    assign zero = (rem_q == '0);

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rem_q) == '0 && !$past(load)) |-> rem_q == '0); // R4
endmodule

// File: rtl/wake_poll_guard.sv
// Module: counts consecutive busy status reads and flags the timeout.
// Assumes clr is given on every command write, before polling starts.
module wake_poll_guard #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic busy_rd,
    output logic expired
);
    localparam int GW = $clog2(LIMIT + 1);
    logic [GW-1:0] cnt_q;

    // Track busy reads since the last write, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (clr)                     cnt_q <= '0;
        else if (busy_rd && !expired)     cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == GW'(LIMIT - 1));

    AST_GUARD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= GW'(LIMIT - 1)); // R7
endmodule

// File: rtl/cpu_wake_seq.sv
// Module: top of the wake-up sequencer. It clears the reported-in counter,
// issues INIT and then two start-up broadcasts, polls delivery status after
// each write, waits the timed gap, and finally compares the processor count.
// Assumes cmd_rdata is valid in the same cycle that cmd_rd is high.
module cpu_wake_seq
    import cpu_wake_pkg::*;
#(
    parameter int CLK_HZ   = 125_000_000,
    parameter int REF_HZ   = 1_193_182,
    parameter int LONG_US  = 10_000,
    parameter int SHORT_US = 200,
    parameter int POLL_MAX = 64,
    parameter int CW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    start_vec,
    input  logic [CW-1:0] exp_count,
    input  logic [CW-1:0] cpu_count,
    output logic          cnt_clr,
    output logic          cmd_wr,
    output logic [31:0]   cmd_wdata,
    output logic          cmd_rd,
    input  logic [31:0]   cmd_rdata,
    output logic          done,
    output logic          pass,
    output logic [CW-1:0] final_count,
    output logic [1:0]    err_code
);
    localparam int DIV          = (CLK_HZ / REF_HZ < 1) ? 1 : CLK_HZ / REF_HZ;
    localparam int LONG_RELOAD  = REF_HZ / (1_000_000 / LONG_US);
    localparam int SHORT_RELOAD = REF_HZ / (1_000_000 / SHORT_US);
    localparam int TW           = $clog2(LONG_RELOAD + 2);

    seq_state_t    state_q;
    logic [1:0]    step_q;
    logic          done_q, pass_q;
    logic [CW-1:0] final_q;
    logic [1:0]    err_q;
    logic          tick, tmr_zero, tmr_load, expired, busy;
    logic [TW-1:0] reload;
    logic          unused_rdata_bits;

    assign busy              = cmd_rdata[PEND_BIT];
    assign unused_rdata_bits = ^{cmd_rdata[31:PEND_BIT+1], cmd_rdata[PEND_BIT-1:0]};
    assign tmr_load          = (state_q == S_POLL) && !busy;
    assign reload            = (step_q == 2'd0) ? TW'(LONG_RELOAD) : TW'(SHORT_RELOAD);

    wake_ref_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    wake_delay_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(reload),
        .tick(tick), .zero(tmr_zero)
    );

    wake_poll_guard #(.LIMIT(POLL_MAX)) u_guard (
        .clk(clk), .rst_n(rst_n), .clr(state_q == S_WRITE),
        .busy_rd((state_q == S_POLL) && busy), .expired(expired)
    );

    // Sequence control and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= 2'd0;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
            final_q <= '0;
            err_q   <= 2'd0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_CLEAR;
                    pass_q  <= 1'b0;
                    final_q <= '0;
                    err_q   <= 2'd0;
                end
                S_CLEAR: begin
                    step_q  <= 2'd0;
                    state_q <= S_WRITE;
                end
                S_WRITE: state_q <= S_POLL;
                S_POLL: begin
                    if (!busy) begin
                        state_q <= S_WAIT;
                    end else if (expired) begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                        err_q   <= step_q + 2'd1;
                    end
                end
                S_WAIT: if (tmr_zero) begin
                    if (step_q == 2'd2) begin
                        state_q <= S_CHECK;
                    end else begin
                        step_q  <= step_q + 2'd1;
                        state_q <= S_WRITE;
                    end
                end
                S_CHECK: begin
                    state_q <= S_IDLE;
                    done_q  <= 1'b1;
                    pass_q  <= (cpu_count == exp_count);
                    final_q <= cpu_count;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Drive the strobes and the command word from the current step.
    always_comb begin
        cnt_clr   = (state_q == S_CLEAR);
        cmd_wr    = (state_q == S_WRITE);
        cmd_rd    = (state_q == S_POLL);
        cmd_wdata = '0;
        if (state_q == S_WRITE)
            cmd_wdata = (step_q == 2'd0) ? build_cmd(MODE_INIT, 8'h00)
                                         : build_cmd(MODE_START, start_vec);
    end

    assign done        = done_q;
    assign pass        = pass_q;
    assign final_count = final_q;
    assign err_code    = err_q;

    AST_INIT_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[10:8] == MODE_INIT) |-> $past(cnt_clr)); // R1
    AST_WAIT_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && $past(state_q) == S_POLL) |-> !$past(cmd_rdata[PEND_BIT])); // R3
    AST_WRITE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && step_q != 2'd0) |-> $past(tmr_zero)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_ABORT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != 2'd0) |-> !pass); // R7
endmodule

// File: tb/cpu_wake_seq_bench.sv
// Bench: a behavioural reference model compared on every clock, plus directed
// checks on outcomes and on the gaps between writes.
module cpu_wake_seq_bench;
    localparam int CLK_HZ   = 238_636;
    localparam int REF_HZ   = 119_318;
    localparam int LONG_US  = 10_000;
    localparam int SHORT_US = 200;
    localparam int POLL_MAX = 16;
    localparam int CW       = 8;
    localparam int DIV      = CLK_HZ / REF_HZ;
    localparam int LONGR    = REF_HZ / (1_000_000 / LONG_US);
    localparam int SHORTR   = REF_HZ / (1_000_000 / SHORT_US);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    start_vec = 8'h11;
    logic [CW-1:0] exp_count = '0;
    logic [CW-1:0] cpu_count = '0;
    logic          cnt_clr, cmd_wr, cmd_rd, done, pass;
    logic [31:0]   cmd_wdata, cmd_rdata;
    logic [CW-1:0] final_count;
    logic [1:0]    err_code;

    int vectors = 0, fails = 0, cyc = 0;
    int pend = 0, n_aps = 0, n_wr = 0;
    int busy_len [0:2];
    int wr_cyc [0:63];
    bit cmp_en = 0;

    // Reference model state.
    int m_st = 0, m_step = 0, m_poll = 0, m_rem = 0, m_div = 0;
    int m_done = 0, m_pass = 0, m_final = 0, m_err = 0;
    logic m_tick;

    always #4 clk = ~clk;

    cpu_wake_seq #(.CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ), .LONG_US(LONG_US),
                   .SHORT_US(SHORT_US), .POLL_MAX(POLL_MAX), .CW(CW)) u_cpu_wake_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_vec(start_vec),
        .exp_count(exp_count), .cpu_count(cpu_count), .cnt_clr(cnt_clr),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rd(cmd_rd),
        .cmd_rdata(cmd_rdata), .done(done), .pass(pass),
        .final_count(final_count), .err_code(err_code)
    );

    assign cmd_rdata = (pend > 0) ? 32'h0000_1000 : 32'h0;
    assign m_tick    = (m_div == DIV - 1);

    function automatic logic [31:0] exp_word(input int step);
        return (step == 0) ? 32'h000C4500 : (32'h000C4600 | {24'h0, start_vec});
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        vectors++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, expv, cyc);
        end
    endtask

    // Command register and processor environment: pending bit, count, write log.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cmd_wr) begin
            pend <= busy_len[m_step];
            wr_cyc[n_wr % 64] <= cyc;
            n_wr <= n_wr + 1;
        end else if (pend > 0) pend <= pend - 1;
        if (cnt_clr) cpu_count <= '0;
        else if (cmd_wr && cmd_wdata[10:8] == 3'b110) cpu_count <= CW'(n_aps);
    end

    // Behavioural reference model of the sequence.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_step <= 0; m_poll <= 0; m_rem <= 0; m_div <= 0;
            m_done <= 0; m_pass <= 0; m_final <= 0; m_err <= 0;
        end else begin
            m_div  <= m_tick ? 0 : m_div + 1;
            m_done <= 0;
            if (m_st == 3 && pend == 0) m_rem <= (m_step == 0) ? LONGR : SHORTR;
            else if (m_tick && m_rem != 0) m_rem <= m_rem - 1;
            case (m_st)
                0: if (start) begin m_st <= 1; m_pass <= 0; m_final <= 0; m_err <= 0; end
                1: begin m_step <= 0; m_st <= 2; end
                2: begin m_poll <= 0; m_st <= 3; end
                3: if (pend == 0) m_st <= 4;
                   else if (m_poll == POLL_MAX - 1) begin
                       m_st <= 0; m_done <= 1; m_err <= m_step + 1;
                   end else m_poll <= m_poll + 1;
                4: if (m_rem == 0) begin
                       if (m_step == 2) m_st <= 5;
                       else begin m_step <= m_step + 1; m_st <= 2; end
                   end
                5: begin m_st <= 0; m_done <= 1; m_pass <= (cpu_count == exp_count);
                         m_final <= int'(cpu_count); end
                default: m_st <= 0;
            endcase
        end
    end

    // Compare every output with the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            check("R1 cnt_clr", cnt_clr, m_st == 1);
            check("R2 cmd_wr", cmd_wr, m_st == 2);
            if (m_st == 2) check("R2 cmd_wdata", cmd_wdata, exp_word(m_step));
            check("R3 cmd_rd", cmd_rd, m_st == 3);
            check("R6 done", done, m_done);
            check("R6 pass", pass, m_pass);
            check("R6 final_count", final_count, m_final);
            check("R7 err_code", err_code, m_err);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150_000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150_000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic run(input int b0, input int b1, input int b2, input int aps,
                       input int expc, input int exp_err, input bit poke);
        int base, waited;
        busy_len[0] = b0; busy_len[1] = b1; busy_len[2] = b2;
        n_aps = aps; exp_count = CW'(expc);
        @(negedge clk);
        base = n_wr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 clear follows start", cnt_clr, 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;                 // R8: mid-sequence start must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 20_000) begin @(negedge clk); waited++; end
        check("R6 done seen", done, 1);
        check("R7 error code", err_code, exp_err);
        check("R2 R7 R8 write count", n_wr - base, (exp_err == 0) ? 3 : exp_err);
        if (exp_err == 0) begin
            check("R6 final count", final_count, aps);
            check("R6 pass flag", pass, aps == expc);
            check("R4 long gap low", (wr_cyc[(base+1)%64] - wr_cyc[base%64]) >= LONGR*DIV, 1);
            check("R4 long gap high", (wr_cyc[(base+1)%64] - wr_cyc[base%64]) <= (LONGR+1)*DIV + b0 + 4, 1);
            check("R5 short gap low", (wr_cyc[(base+2)%64] - wr_cyc[(base+1)%64]) >= SHORTR*DIV, 1);
            check("R5 short gap high", (wr_cyc[(base+2)%64] - wr_cyc[(base+1)%64]) <= (SHORTR+1)*DIV + b1 + 4, 1);
        end else begin
            check("R7 abort pass", pass, 0);
            check("R7 abort count", final_count, 0);
        end
        repeat (40) @(negedge clk);
        check("R7 no write after end", n_wr - base, (exp_err == 0) ? 3 : exp_err);
    endtask

    initial begin
        busy_len[0] = 0; busy_len[1] = 0; busy_len[2] = 0;
        repeat (4) @(negedge clk);
        check("R9 reset done", done, 0);
        check("R9 reset cmd_wr", cmd_wr, 0);
        check("R9 reset err", err_code, 0);
        rst_n = 1'b1;
        cmp_en = 1;
        @(negedge clk);
        check("R9 idle pass", pass, 0);
        check("R9 idle final", final_count, 0);
        run(3, 0, 5, 3, 3, 0, 0);          // full pass
        start_vec = 8'h2A;
        run(0, 2, 1, 2, 5, 0, 1);          // count mismatch, stray start
        run(0, 100, 0, 2, 2, 2, 0);        // stall on first start-up
        run(100, 0, 0, 1, 1, 1, 0);        // stall on INIT
        run(1, 1, 100, 4, 4, 3, 0);        // stall on second start-up
        run(0, 0, 0, 7, 7, 0, 0);          // recovery after abort
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule